// File: doc/BRIEF.md
# Hub Downstream Port Power and Indicator Controller

This block manages the power switch enable and the user status indicator of each downstream port of a hub. It receives already decoded host requests as one-cycle strobes (apply or remove port power, enable or disable a port, clear an over-current change flag, hub re-initialisation) together with a level that says the hub is configured. It also receives one asynchronous active-high overcurrent flag per port from the external power switches.

The overcurrent flags are synchronised and debounced on a slow prescaled tick. A qualified overcurrent cuts power to its port, disables it, raises a sticky change bit for the hub status logic, and turns the port indicator into a slow blinking light. The blinking stops when the host removes power from the port or re-initialises the hub. The indicator otherwise shows whether the port is enabled. The blink half period is a count of ticks, so with a tick of about 1 kHz the default gives roughly one second per blink cycle.

Top module: `hub_port_pwr_ctrl`

## Requirements
- R1: A port's power output rises only at the clock edge that samples a power-apply strobe for that port while the hub is configured, with that port neither in the fault state nor reporting a filtered overcurrent. Other ports keep their power state.
- R2: All power outputs are low during and after reset. A power-remove strobe for a port drives its power output low at the next edge.
- R3: No power-apply strobe has any effect while the hub-configured input is low.
- R4: Each overcurrent input passes through two synchronising flops. It becomes a filtered overcurrent only after the synchronised value has been high on FILT_TICKS consecutive ticks, with a default of 4. Any low synchronised sample restarts the count and clears the filtered value.
- R5: At the edge where a port's filtered overcurrent rises, that port's power goes low, its enable drops, its change bit is set and it enters the fault state.
- R6: The over-current status output equals the filtered overcurrent. The change bit stays set until a change-clear strobe for that port or a hub re-initialisation. A new rise wins over a simultaneous clear.
- R7: The indicator is low by default. Outside the fault state it is high exactly while the port is enabled. An enable strobe is accepted only for a powered port outside the fault state. A disable strobe or the removal of power makes the port disabled.
- R8: In the fault state the indicator follows a blink phase that is shared by all ports. The phase is 0 after reset and inverts after every BLINK_HALF ticks, so after k ticks it is (k / BLINK_HALF) mod 2.
- R9: The fault state, and with it the blinking, ends only on a power-remove strobe for that port or on a hub re-initialisation. A power-apply strobe for a port in the fault state is ignored.
- R10: A hub re-initialisation strobe clears power, enable, fault state and change bit of every port at the next edge. The over-current status keeps following the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle prescaled timing pulse |
| hub_configured | input | 1 | Level: the host has configured the hub |
| hub_reinit | input | 1 | Strobe: hub reset or re-enumeration |
| pwr_set | input | NPORTS | Strobe per port: apply power |
| pwr_clr | input | NPORTS | Strobe per port: remove power |
| en_set | input | NPORTS | Strobe per port: enable port |
| en_clr | input | NPORTS | Strobe per port: disable port |
| oc_chg_clr | input | NPORTS | Strobe per port: clear over-current change bit |
| oc_in | input | NPORTS | Asynchronous active-high overcurrent flags |
| port_pwr | output | NPORTS | Power switch enable per port |
| port_ind | output | NPORTS | Status indicator per port |
| oc_stat | output | NPORTS | Filtered over-current status per port |
| oc_chg | output | NPORTS | Sticky over-current change bit per port |

## Verification
Every request strobe changes the registered outputs at the first edge that samples it. The bench drives stimulus on the falling edge and samples at the next falling edge. An overcurrent input reaches the synchroniser output two edges after it changes, so the bench waits three cycles before it gives ticks. It then checks that status and power are unchanged after FILT_TICKS-1 ticks and have changed after the last one. A falling input clears the status on the third edge. For the blink, the bench keeps its own count of ticks since reset, predicts the phase from that count, and compares it after every tick.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;
    typedef struct packed {
        logic pwr;
        logic en;
        logic fault;
        logic chg;
    } port_st_t;
endpackage

// File: rtl/hub_oc_filter.sv
module hub_oc_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oc_raw,
    output logic filt_q,
    output logic filt_nxt
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] FMAX = CW'(FILT_TICKS);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          filt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = oc_raw;
        st_d.s2 = st_q.s1;
        if (!st_q.s2) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt != FMAX) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        st_d.filt = (st_d.cnt == FMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_q   = st_q.filt;
    assign filt_nxt = st_d.filt;
endmodule

// File: rtl/hub_blink_gen.sv
module hub_blink_gen #(
    parameter int BLINK_HALF = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic phase
);
    localparam int BW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [BW-1:0] LAST = BW'(BLINK_HALF - 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          ph;
    } blk_t;

    blk_t bl_d, bl_q;

    always_comb begin
        bl_d = bl_q;
        if (tick) begin
            if (bl_q.cnt == LAST) begin
                bl_d.cnt = '0;
                bl_d.ph  = ~bl_q.ph;
            end else begin
                bl_d.cnt = bl_q.cnt + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end

    assign phase = bl_q.ph;
endmodule

// File: rtl/hub_port_fsm.sv
module hub_port_fsm
    import hub_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg,
    input  logic reinit,
    input  logic pwr_set,
    input  logic pwr_clr,
    input  logic en_set,
    input  logic en_clr,
    input  logic chg_clr,
    input  logic filt_q,
    input  logic filt_nxt,
    input  logic blink,
    output logic pwr,
    output logic ind,
    output logic chg
);
    port_st_t ps_d, ps_q;
    logic     oc_rise;

    assign oc_rise = filt_nxt & ~filt_q;

    always_comb begin
        ps_d = ps_q;
        if (reinit) begin
            ps_d = '0;
        end else if (oc_rise) begin
            ps_d.pwr   = 1'b0;
            ps_d.en    = 1'b0;
            ps_d.fault = 1'b1;
            ps_d.chg   = 1'b1;
        end else begin
            if (chg_clr) ps_d.chg = 1'b0;
            if (pwr_clr) begin
                ps_d.pwr   = 1'b0;
                ps_d.en    = 1'b0;
                ps_d.fault = 1'b0;
            end else if (pwr_set && cfg && !filt_q && !ps_q.fault) begin
                ps_d.pwr = 1'b1;
            end
            if (en_clr) begin
                ps_d.en = 1'b0;
            end else if (en_set && ps_d.pwr && !ps_d.fault) begin
                ps_d.en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign pwr = ps_q.pwr;
    assign chg = ps_q.chg;
    assign ind = ps_q.fault ? blink : ps_q.en;
endmodule

// File: rtl/hub_port_pwr_ctrl.sv
module hub_port_pwr_ctrl #(
    parameter int NPORTS     = 4,
    parameter int FILT_TICKS = 4,
    parameter int BLINK_HALF = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hub_configured,
    input  logic              hub_reinit,
    input  logic [NPORTS-1:0] pwr_set,
    input  logic [NPORTS-1:0] pwr_clr,
    input  logic [NPORTS-1:0] en_set,
    input  logic [NPORTS-1:0] en_clr,
    input  logic [NPORTS-1:0] oc_chg_clr,
    input  logic [NPORTS-1:0] oc_in,
    output logic [NPORTS-1:0] port_pwr,
    output logic [NPORTS-1:0] port_ind,
    output logic [NPORTS-1:0] oc_stat,
    output logic [NPORTS-1:0] oc_chg
);
    logic              blink;
    logic [NPORTS-1:0] filt_nxt;

    hub_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .tick(tick), .phase(blink)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hub_oc_filter #(.FILT_TICKS(FILT_TICKS)) u_flt (
            .clk(clk), .rst_n(rst_n), .tick(tick), .oc_raw(oc_in[p]),
            .filt_q(oc_stat[p]), .filt_nxt(filt_nxt[p])
        );
        hub_port_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .cfg(hub_configured), .reinit(hub_reinit),
            .pwr_set(pwr_set[p]), .pwr_clr(pwr_clr[p]),
            .en_set(en_set[p]), .en_clr(en_clr[p]), .chg_clr(oc_chg_clr[p]),
            .filt_q(oc_stat[p]), .filt_nxt(filt_nxt[p]), .blink(blink),
            .pwr(port_pwr[p]), .ind(port_ind[p]), .chg(oc_chg[p])
        );
    end
endmodule

// File: rtl/hub_port_pwr_chk.sv
module hub_port_pwr_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hub_configured,
    input logic              hub_reinit,
    input logic [NPORTS-1:0] pwr_set,
    input logic [NPORTS-1:0] pwr_clr,
    input logic [NPORTS-1:0] oc_chg_clr,
    input logic [NPORTS-1:0] port_pwr,
    input logic [NPORTS-1:0] port_ind,
    input logic [NPORTS-1:0] oc_stat,
    input logic [NPORTS-1:0] oc_chg
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R3
        pwr_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_pwr[p]) |-> $past(hub_configured));
        // R1
        pwr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_pwr[p]) |-> $past(pwr_set[p]));
        // R5
        oc_cuts_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(oc_stat[p]) |-> (!port_pwr[p] && oc_chg[p]));
        // R2
        clr_drops_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_clr[p] |=> !port_pwr[p]);
        // R6
        chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (oc_chg[p] && !oc_chg_clr[p] && !hub_reinit) |=> oc_chg[p]);
    end
    // R10
    reinit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hub_reinit |=> (port_pwr == '0 && port_ind == '0 && oc_chg == '0));
endmodule

bind hub_port_pwr_ctrl hub_port_pwr_chk #(.NPORTS(NPORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .hub_configured(hub_configured), .hub_reinit(hub_reinit),
    .pwr_set(pwr_set), .pwr_clr(pwr_clr), .oc_chg_clr(oc_chg_clr),
    .port_pwr(port_pwr), .port_ind(port_ind), .oc_stat(oc_stat), .oc_chg(oc_chg)
);

// File: tb/sim_hub_port_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_hub_port_pwr_ctrl;
    localparam int N  = 4;
    localparam int FT = 4;
    localparam int BH = 5;

    logic clk = 0, rst_n = 0, tick = 0, cfg = 0, reinit = 0;
    logic [N-1:0] pwr_set = 0, pwr_clr = 0, en_set = 0, en_clr = 0, chg_clr = 0, oc_in = 0;
    logic [N-1:0] port_pwr, port_ind, oc_stat, oc_chg;
    int checks = 0, errors = 0, tick_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hub_port_pwr_ctrl #(.NPORTS(N), .FILT_TICKS(FT), .BLINK_HALF(BH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hub_configured(cfg), .hub_reinit(reinit),
        .pwr_set(pwr_set), .pwr_clr(pwr_clr), .en_set(en_set), .en_clr(en_clr),
        .oc_chg_clr(chg_clr), .oc_in(oc_in),
        .port_pwr(port_pwr), .port_ind(port_ind), .oc_stat(oc_stat), .oc_chg(oc_chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1; @(negedge clk); tick = 0; tick_cnt++;
    endtask

    task automatic req(input logic [N-1:0] ps, pc, es, ec, cc, input logic ri);
        pwr_set = ps; pwr_clr = pc; en_set = es; en_clr = ec; chg_clr = cc; reinit = ri;
        @(negedge clk);
        pwr_set = 0; pwr_clr = 0; en_set = 0; en_clr = 0; chg_clr = 0; reinit = 0;
    endtask

    task automatic t_reset();
        chk("R2 reset pwr", 32'(port_pwr), 0);
        chk("R7 reset ind", 32'(port_ind), 0);
        chk("R6 reset stat/chg", 32'({oc_stat, oc_chg}), 0);
    endtask

    task automatic t_unconfigured();
        req(4'hF, 0, 0, 0, 0, 0);
        chk("R3 set ignored unconfigured", 32'(port_pwr), 0);
    endtask

    task automatic t_power_enable();
        cfg = 1;
        req(4'b0101, 0, 0, 0, 0, 0);
        chk("R1 selected ports powered", 32'(port_pwr), 32'b0101);
        req(0, 0, 4'b0011, 0, 0, 0);
        chk("R7 enable only powered port", 32'(port_ind), 32'b0001);
        req(0, 0, 0, 4'b0001, 0, 0);
        chk("R7 disable drops ind", 32'(port_ind), 0);
        req(0, 0, 4'b0001, 0, 0, 0);
        chk("R7 re-enable", 32'(port_ind), 32'b0001);
        req(0, 4'b0100, 0, 0, 0, 0);
        chk("R2 clear one port", 32'(port_pwr), 32'b0001);
        req(0, 4'b0001, 0, 0, 0, 0);
        chk("R2 clear last port", 32'(port_pwr), 0);
        chk("R7 power removal disables", 32'(port_ind), 0);
    endtask

    task automatic t_fault();
        req(4'b0010, 0, 0, 0, 0, 0);
        req(0, 0, 4'b0010, 0, 0, 0);
        chk("R7 port1 enabled", 32'(port_ind), 32'b0010);
        oc_in = 4'b0010; cyc(3);
        repeat (FT - 1) do_tick();
        chk("R4 not yet qualified", 32'({oc_stat, port_pwr}), 32'b0000_0010);
        oc_in = 0; cyc(3);
        repeat (FT) do_tick();
        chk("R4 glitch restarts count", 32'(oc_stat), 0);
        oc_in = 4'b0010; cyc(3);
        repeat (FT - 1) do_tick();
        chk("R4 boundary minus one", 32'(oc_stat), 0);
        do_tick();
        chk("R5 stat set", 32'(oc_stat), 32'b0010);
        chk("R5 chg set", 32'(oc_chg), 32'b0010);
        chk("R5 power cut", 32'(port_pwr), 0);
        for (int k = 0; k < 2 * BH + 1; k++) begin
            do_tick();
            chk("R8 blink phase", 32'(port_ind[1]), 32'((tick_cnt / BH) % 2));
        end
        req(4'b0010, 0, 0, 0, 0, 0);
        chk("R9 set ignored in fault", 32'(port_pwr), 0);
        oc_in = 0; cyc(2);
        chk("R6 stat holds two edges", 32'(oc_stat), 32'b0010);
        cyc(1);
        chk("R6 stat follows filter", 32'(oc_stat), 0);
        chk("R6 chg sticky", 32'(oc_chg), 32'b0010);
        while (((tick_cnt / BH) % 2) == 0) do_tick();
        chk("R9 still blinking after oc gone", 32'(port_ind[1]), 1);
        req(0, 0, 0, 0, 4'b0010, 0);
        chk("R6 chg cleared", 32'(oc_chg), 0);
        req(0, 4'b0010, 0, 0, 0, 0);
        chk("R9 clear power ends blink", 32'(port_ind), 0);
        req(4'b0010, 0, 0, 0, 0, 0);
        chk("R9 power again after clear", 32'(port_pwr), 32'b0010);
    endtask

    task automatic t_reinit();
        req(4'b0001, 0, 4'b0011, 0, 0, 0);
        oc_in = 4'b1000; cyc(3);
        repeat (FT) do_tick();
        chk("R5 port3 fault chg", 32'(oc_chg), 32'b1000);
        req(0, 0, 0, 0, 0, 1);
        chk("R10 reinit pwr", 32'(port_pwr), 0);
        chk("R10 reinit ind", 32'(port_ind), 0);
        chk("R10 reinit chg", 32'(oc_chg), 0);
        chk("R10 stat follows filter", 32'(oc_stat), 32'b1000);
        req(4'b1000, 0, 0, 0, 0, 0);
        chk("R1 set ignored during overcurrent", 32'(port_pwr), 0);
        oc_in = 0; cyc(3);
        req(4'b1000, 0, 0, 0, 0, 0);
        chk("R1 set after overcurrent clears", 32'(port_pwr), 32'b1000);
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        t_reset();
        t_unconfigured();
        t_power_enable();
        t_fault();
        t_reinit();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule